// File: doc/BRIEF.md
# Serial RGB LCD Timing Generator

This block drives a small TFT panel that takes one colour byte per clock on an 8-bit bus. A 24-bit pixel therefore goes out over three clocks. The block produces active-low horizontal and vertical sync, a data-enable window and the data bytes. It fetches 16-bit words from a valid/ready source and splits each word into two bytes, low byte first. The source is expected to store pixel components in red, green, blue order, so the byte stream reaches the panel in that order.

One free-running pair of counters, one for clocks within a line and one for lines within a frame, times every output. This keeps the sync edges and the data window locked together. With the default parameters, a line lasts 1224 clocks and the sync pulse is low for the first 90 of them. Data starts 204 clocks after the sync edge and lasts 960 clocks. A frame has 241 lines: one blanking line, then 240 active lines. Vertical sync is low for the first 3 lines of each frame.

An enable input starts and stops the stream. When the source has nothing to offer at a byte that needs a new word, the block sends zero and raises a sticky underrun flag. It then accepts and discards every word offered until the frame ends, and resumes clean data at the next frame.

Top module: `serial_rgb_timing`

## Requirements
- R1: While the block is not running, pixClkEn is 0, hsyncN and vsyncN are 1, de is 0, dataOut is 0 and srcReady is 0.
- R2: When enable is sampled high while the block is stopped, the next clock is clock 0 of line 0 (hsyncN and vsyncN low) and pixClkEn is 1 from then on. Counting resumes from there after every stop, including one made mid-line.
- R3: hsyncN is 0 exactly on the first H_SYNC clocks of every H_TOTAL-clock line.
- R4: vsyncN is 0 exactly on the first V_SYNC lines of every V_LINES-line frame.
- R5: de is 1 only on lines numbered V_BLANK and above, for H_ACTIVE clocks starting at clock H_START of the line. dataOut is 0 whenever de is 0.
- R6: In normal operation, srcReady is 1 only on de clocks that start a new word. The accepted word's bits [7:0] appear on dataOut in that same clock, and its bits [15:8] appear on the following de clock. That following byte needs no valid source.
- R7: If srcValid is 0 on a de clock that needs a new word, dataOut is 0 in that clock and underrun reads 1 from the next clock on. The flag stays 1 while running, and it clears once the block has been stopped.
- R8: After an underrun, until the last clock of the frame, srcReady is 1 on every clock, offered words are discarded, and dataOut stays 0.
- R9: From the first clock of the next frame, operation is normal again: the first de clock sends bits [7:0] of the word then being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run (1) or stop (0) |
| srcData | input | WORD_W | Word from the pixel source |
| srcValid | input | 1 | Source word is valid |
| srcReady | output | 1 | Word is taken in this clock |
| pixClkEn | output | 1 | Panel clock enable, high while running |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| de | output | 1 | Data-enable window |
| dataOut | output | BYTE_W | Colour byte to the panel |
| underrun | output | 1 | Sticky source-starved flag |

## Verification
A wrong line or frame count shows up within one line period as a sync pulse or data window at the wrong clock. A wrong byte-lane state swaps or repeats bytes on the very next de clock. A drop state that fails to set or clear shows up as nonzero data during a dropped frame, or as zeros after the frame restart. The bench therefore compares every output on every clock against a model of the line and frame position. It runs a reduced geometry so that whole frames, a mid-line stop, an underrun with drained words, and source stalls on high-byte clocks all fit in a short run.

// File: rtl/serial_rgb_timing_pkg.sv
package serial_rgb_timing_pkg;

  // Strobes passed from the timing control to the byte datapath.
  typedef struct packed {
    logic running;   // counters are live
    logic hsyncAct;  // inside horizontal sync pulse
    logic vsyncAct;  // inside vertical sync pulse
    logic active;    // inside the data window
    logic frameEnd;  // last clock of the frame
  } tgStrobe_t;

endpackage

// File: rtl/serial_rgb_timing_ctl.sv
module serial_rgb_timing_ctl
  import serial_rgb_timing_pkg::*;
#(
  parameter int H_TOTAL  = 1224,
  parameter int H_SYNC   = 90,
  parameter int H_START  = 204,
  parameter int H_ACTIVE = 960,
  parameter int V_LINES  = 241,
  parameter int V_SYNC   = 3,
  parameter int V_BLANK  = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  output tgStrobe_t strobe
);

  localparam int HW = $clog2(H_TOTAL + 1);
  localparam int VW = $clog2(V_LINES + 1);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_SY   = HW'(H_SYNC);
  localparam logic [HW-1:0] H_ON   = HW'(H_START);
  localparam logic [HW-1:0] H_OFF  = HW'(H_START + H_ACTIVE);
  localparam logic [VW-1:0] V_LAST = VW'(V_LINES - 1);
  localparam logic [VW-1:0] V_SY   = VW'(V_SYNC);
  localparam logic [VW-1:0] V_BL   = VW'(V_BLANK);

  logic          running;
  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic          lineEnd;

  assign lineEnd = (hCnt == H_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      hCnt    <= '0;
      vCnt    <= '0;
    end else if (!enable || !running) begin
      // Stopped, or the start clock: park at line 0, clock 0.
      running <= enable;
      hCnt    <= '0;
      vCnt    <= '0;
    end else begin
      hCnt <= lineEnd ? '0 : hCnt + 1'b1;
      if (lineEnd) begin
        vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.running  = running;
    strobe.hsyncAct = running && (hCnt < H_SY);
    strobe.vsyncAct = running && (vCnt < V_SY);
    strobe.active   = running && (vCnt >= V_BL) && (hCnt >= H_ON) && (hCnt < H_OFF);
    strobe.frameEnd = running && lineEnd && (vCnt == V_LAST);
  end

endmodule

// File: rtl/serial_rgb_timing_dp.sv
module serial_rgb_timing_dp
  import serial_rgb_timing_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgStrobe_t         strobe,
  input  logic [WORD_W-1:0] srcData,
  input  logic              srcValid,
  output logic              srcReady,
  output logic [BYTE_W-1:0] dataOut,
  output logic              underrun
);

  localparam int LANES = WORD_W / BYTE_W;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LW-1:0] LANE_LAST = LW'(LANES - 1);

  logic [WORD_W-1:0] heldWord;
  logic [LW-1:0]     lane;
  logic              dropping;
  logic [BYTE_W-1:0] laneByte [LANES];

  // Byte lanes of the held word, lane 0 least significant.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneByte[i] = heldWord[i*BYTE_W +: BYTE_W];
  end

  logic needWord, take, starve;
  assign needWord = strobe.active && !dropping && (lane == '0);
  assign take     = needWord && srcValid;
  assign starve   = needWord && !srcValid;
  assign srcReady = strobe.running && (dropping || needWord);

  always_comb begin
    dataOut = '0;
    if (strobe.active && !dropping) begin
      if (lane == '0) dataOut = take ? srcData[BYTE_W-1:0] : '0;
      else            dataOut = laneByte[lane];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
      lane     <= '0;
      dropping <= 1'b0;
      underrun <= 1'b0;
    end else if (!strobe.running) begin
      lane     <= '0;
      dropping <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (starve) begin
        dropping <= 1'b1;
        underrun <= 1'b1;
      end else if (strobe.active && !dropping) begin
        if (take) heldWord <= srcData;
        lane <= (lane == LANE_LAST) ? '0 : lane + 1'b1;
      end
      if (strobe.frameEnd) begin
        lane     <= '0;
        dropping <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_rgb_timing.sv
module serial_rgb_timing
  import serial_rgb_timing_pkg::*;
#(
  parameter int H_TOTAL  = 1224,
  parameter int H_SYNC   = 90,
  parameter int H_START  = 204,
  parameter int H_ACTIVE = 960,
  parameter int V_LINES  = 241,
  parameter int V_SYNC   = 3,
  parameter int V_BLANK  = 1,
  parameter int WORD_W   = 16,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [WORD_W-1:0] srcData,
  input  logic              srcValid,
  output logic              srcReady,
  output logic              pixClkEn,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              de,
  output logic [BYTE_W-1:0] dataOut,
  output logic              underrun
);

  tgStrobe_t strobe;

  serial_rgb_timing_ctl #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_START(H_START), .H_ACTIVE(H_ACTIVE),
    .V_LINES(V_LINES), .V_SYNC(V_SYNC), .V_BLANK(V_BLANK)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .strobe(strobe)
  );

  serial_rgb_timing_dp #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcData(srcData), .srcValid(srcValid), .srcReady(srcReady),
    .dataOut(dataOut), .underrun(underrun)
  );

  assign pixClkEn = strobe.running;
  assign hsyncN   = !strobe.hsyncAct;
  assign vsyncN   = !strobe.vsyncAct;
  assign de       = strobe.active;

endmodule

// File: rtl/serial_rgb_timing_chk.sv
module serial_rgb_timing_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              srcReady,
  input logic              pixClkEn,
  input logic              hsyncN,
  input logic              vsyncN,
  input logic              de,
  input logic [BYTE_W-1:0] dataOut,
  input logic              underrun
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !pixClkEn |-> (hsyncN && vsyncN && !de && (dataOut == '0) && !srcReady));

  p_start_at_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pixClkEn) |-> (!hsyncN && !vsyncN));

  p_window_after_sync_r5: assert property (@(posedge clk) disable iff (!rstN)
    de |-> hsyncN);

  p_zero_outside_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    !de |-> (dataOut == '0));

  p_ready_needs_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> pixClkEn);

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && enable && pixClkEn) |=> underrun);

endmodule

bind serial_rgb_timing serial_rgb_timing_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .srcReady(srcReady),
  .pixClkEn(pixClkEn), .hsyncN(hsyncN), .vsyncN(vsyncN), .de(de),
  .dataOut(dataOut), .underrun(underrun)
);

// File: tb/serial_rgb_timing_tb.sv
module serial_rgb_timing_tb;

  localparam int HT = 12, HS = 3, HST = 4, HA = 6, VL = 5, VS = 2, VB = 1;
  localparam int FR = HT * VL;

  logic        clk = 1'b0, rstN = 1'b0, enable = 1'b0, srcValid = 1'b0;
  logic [15:0] srcData = '0;
  logic        srcReady, pixClkEn, hsyncN, vsyncN, de, underrun;
  logic [7:0]  dataOut;

  serial_rgb_timing #(
    .H_TOTAL(HT), .H_SYNC(HS), .H_START(HST), .H_ACTIVE(HA),
    .V_LINES(VL), .V_SYNC(VS), .V_BLANK(VB), .WORD_W(16), .BYTE_W(8)
  ) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .srcData(srcData),
    .srcValid(srcValid), .srcReady(srcReady), .pixClkEn(pixClkEn),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .de(de), .dataOut(dataOut),
    .underrun(underrun)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int t = 0, w = 0, phase = 0, dropE = 0, uflagE = 0, lastHi = 0, resumeE = 0;
  int scen = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0d)", req, what, act, exp, t);
    end
  endtask

  function automatic bit validFor(int tt);
    if (scen == 0) return 1'b1;
    if (tt >= 20 && tt < 30) return 1'b0;                       // starve in frame 1
    if (tt >= FR && tt < 2*FR && ((tt % HT) % 2 == 1)) return 1'b0; // stall on high-byte clocks
    return 1'b1;
  endfunction

  task automatic driveWord();
    srcData = {8'(2*w + 1), 8'(2*w)};
  endtask

  task automatic activeStep();
    int h, l, eData, eReady;
    bit eDe, take, starve, fire;
    @(negedge clk);
    h = t % HT;
    l = (t / HT) % VL;
    eDe = (l >= VB) && (h >= HST) && (h < HST + HA);
    take = 0; starve = 0;
    if (dropE != 0) begin
      eReady = 1; eData = 0;
      check("R8", "dataOut while dropping", int'(dataOut), 0);
    end else if (eDe && phase == 0) begin
      eReady = 1;
      if (srcValid) begin
        eData = (2*w) & 255; take = 1;
        if (resumeE != 0) check("R9", "first byte after restart", int'(dataOut), eData);
        else              check("R6", "low byte", int'(dataOut), eData);
        resumeE = 0;
      end else begin
        eData = 0; starve = 1;
        check("R7", "starved byte", int'(dataOut), 0);
      end
    end else if (eDe) begin
      eReady = 0; eData = lastHi;
      check("R6", "high byte", int'(dataOut), eData);
    end else begin
      eReady = 0; eData = 0;
      check("R5", "dataOut outside window", int'(dataOut), 0);
    end
    check("R2", "pixClkEn", int'(pixClkEn), 1);
    check("R3", "hsyncN", int'(hsyncN), (h < HS) ? 0 : 1);
    check("R4", "vsyncN", int'(vsyncN), (l < VS) ? 0 : 1);
    check("R5", "de", int'(de), int'(eDe));
    check((dropE != 0) ? "R8" : "R6", "srcReady", int'(srcReady), eReady);
    check("R7", "underrun", int'(underrun), uflagE);
    fire = srcReady && srcValid;
    if (take) begin lastHi = (2*w + 1) & 255; phase = 1; end
    else if (eDe && dropE == 0 && phase == 1) phase = 0;
    if (starve) begin dropE = 1; uflagE = 1; end
    if (h == HT-1 && l == VL-1) begin
      if (dropE != 0) resumeE = 1;
      dropE = 0; phase = 0;
    end
    @(posedge clk); #1;
    if (fire) w++;
    driveWord();
    t++;
    srcValid = validFor(t);
  endtask

  task automatic idleStep(bit chkU);
    @(negedge clk);
    check("R1", "pixClkEn idle", int'(pixClkEn), 0);
    check("R1", "hsyncN idle", int'(hsyncN), 1);
    check("R1", "vsyncN idle", int'(vsyncN), 1);
    check("R1", "de idle", int'(de), 0);
    check("R1", "dataOut idle", int'(dataOut), 0);
    check("R1", "srcReady idle", int'(srcReady), 0);
    if (chkU) check("R7", "underrun cleared by stop", int'(underrun), 0);
    @(posedge clk); #1;
  endtask

  task automatic startRun(int s);
    scen = s; t = 0; phase = 0; dropE = 0; uflagE = 0; resumeE = 0;
    driveWord();
    srcValid = validFor(0);
    enable = 1'b1;
    idleStep(1);
  endtask

  task automatic stopRun();
    enable = 1'b0;
    activeStep();
    idleStep(0);
    idleStep(1);
    idleStep(1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    for (int i = 0; i < 3; i++) idleStep(1);   // R1 after reset

    // Two full frames plus a partial line, source always ready (R2..R6).
    startRun(0);
    for (int i = 0; i < 2*FR + 7; i++) activeStep();
    stopRun();

    // Restart after mid-line stop, underrun, drain, resume, high-byte stalls.
    startRun(1);
    for (int i = 0; i < 3*FR; i++) activeStep();
    stopRun();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule